// File: doc/BRIEF.md
# Addressed Serial Display-Bank Receiver

This block takes frames from a three-wire serial link made of an enable line, a serial clock and a data line. All three lines come from outside the system clock domain and are brought in through synchronizer stages before any edge detection. While the enable line is low, the block shifts in a device address. When the enable line rises, the address is compared with the block's own. If the address matches, the data bits clocked while enable is high are gathered into a payload register.

When the enable line falls, the last bit of the payload selects one of two register banks. The "low" bank holds the first 44 display bits and a set of control fields. The "high" bank holds the second 44 display bits. A bank is written only when the frame was complete and well formed. Each bank has a one-cycle strobe that pulses when the bank takes new contents, so downstream display logic can reload.

A panel with 44 segments or fewer needs only low-bank frames. A full panel takes one frame of each kind, in either order.

Top module: `addr_frame_rx`

## Requirements
- R1: Out of reset, both display banks and every control field read zero, and both update strobes are low.
- R2: On each rising edge of the serial clock while enable is low, one address bit is taken, least significant bit first. The last 8 bits taken before enable rises must equal 0x44 (sent as 0,0,1,0,0,0,1,0). Any other address makes the frame change nothing.
- R3: Payload bits are counted from 1, and each is sampled on a serial-clock rising edge while enable is high. In a low-bank frame, payload bit k for k = 1..44 lands on `disp_lo[k-1]`.
- R4: In a low-bank frame, payload bits 50, 51 and 52 set `port_sel[0]`, `port_sel[1]` and `port_sel[2]`. Bit 53 sets `bias_half`, bit 54 sets `seg_blank` and bit 55 sets `save_mode`. Payload bits 45 to 49 have no effect.
- R5: Payload bit 56 is the direction bit: 0 selects the low bank and 1 selects the high bank. In a high-bank frame, payload bit k for k = 1..44 lands on `disp_hi[k-1]`. Such a frame is taken only if payload bits 45 to 55 are all zero; otherwise it changes nothing.
- R6: A frame is taken only when exactly 56 payload bits arrived. A frame with 55 or 57 bits leaves both banks and all control fields unchanged.
- R7: Bank contents change only as a result of an enable falling edge. The bank written raises its strobe for exactly one cycle, in the same cycle its new contents appear. Serial clocking with enable held low never changes a bank.
- R8: A low-bank frame leaves `disp_hi` unchanged. A high-bank frame leaves `disp_lo` and every control field unchanged.
- R9: Two valid frames sent back to back, one for each bank, both take effect, each with its own strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial enable line (asynchronous) |
| ser_clk | input | 1 | Serial clock line (asynchronous) |
| ser_dat | input | 1 | Serial data line (asynchronous) |
| disp_lo | output | 44 | Display bits 1..44 |
| disp_hi | output | 44 | Display bits 45..88 |
| port_sel | output | 3 | Output-port selection control field |
| bias_half | output | 1 | Bias-scheme control field |
| seg_blank | output | 1 | Segment blanking control field |
| save_mode | output | 1 | Power-saving control field |
| upd_lo | output | 1 | One-cycle strobe when the low bank is written |
| upd_hi | output | 1 | One-cycle strobe when the high bank is written |

## Verification
The bench builds the block with its default parameters: an 8-bit address of 0x44, 44 display bits per bank and two synchronizer stages. With these values the real 56-bit frame length is in use, so the exact-count boundary can be driven directly with 55-bit and 57-bit frames. The bench also exercises:
- address mismatch;
- nonzero fixed bits in a high-bank frame;
- ignored padding bits in a low-bank frame;
- address clocking with no payload phase;
- back-to-back frames for the two banks.

Each serial phase lasts four system clocks, so every serial edge clears the synchronizers well apart from the others.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    // Zero padding bits that precede the control fields in a payload
    localparam int PAD_BITS = 5;
    // Number of live control bits
    localparam int CFG_BITS = 6;
    localparam int CTRL_W   = PAD_BITS + CFG_BITS;

    typedef struct packed {
        logic       save_mode;
        logic       seg_blank;
        logic       bias_half;
        logic [2:0] port_sel;
    } ctrl_t;
endpackage

// File: rtl/rxc_sync.sv
module rxc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] st_d;
        if (s == 0) begin : g_first
            assign st_d = d;
        end else begin : g_next
            assign st_d = st_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[s] <= '0;
            else        st_q[s] <= st_d;
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/rxc_frame.sv
module rxc_frame #(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  DEV_ADDR = 8'h44,
    parameter int          DISP_W   = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sck,
    input  logic dat,
    output logic cmt_lo,
    output logic cmt_hi,
    output logic [DISP_W+rxc_pkg::CTRL_W:0] pay
);
    import rxc_pkg::*;
    localparam int PAY_W = DISP_W + CTRL_W + 1;
    localparam int CNT_W = $clog2(PAY_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAY_W);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(PAY_W + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [PAY_W-1:0]  pay;
        logic [CNT_W-1:0]  cnt;
        logic              match;
        logic              ce_p;
        logic              sck_p;
    } st_t;

    st_t s_d, s_q;
    logic sck_rise, ce_rise, ce_fall, good, dir, fixed_zero;

    always_comb begin
        s_d      = s_q;
        s_d.ce_p  = ce;
        s_d.sck_p = sck;
        sck_rise = sck & ~s_q.sck_p;
        ce_rise  = ce & ~s_q.ce_p;
        ce_fall  = ~ce & s_q.ce_p;
        if (ce_rise) begin
            s_d.match = (s_q.addr == DEV_ADDR[ADDR_W-1:0]);
            s_d.cnt   = '0;
        end else if (ce_fall) begin
            s_d.match = 1'b0;
        end else if (sck_rise) begin
            if (!ce) begin
                s_d.addr = {dat, s_q.addr[ADDR_W-1:1]};
            end else if (s_q.match) begin
                s_d.pay = {dat, s_q.pay[PAY_W-1:1]};
                if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        good       = ce_fall & s_q.match & (s_q.cnt == CNT_FULL);
        dir        = s_q.pay[PAY_W-1];
        fixed_zero = (s_q.pay[PAY_W-2:DISP_W] == '0);
        cmt_lo     = good & ~dir;
        cmt_hi     = good & dir & fixed_zero;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pay = s_q.pay;

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_MAX);
    // R8
    one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmt_lo && cmt_hi));
    // R7
    commit_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_lo || cmt_hi) |-> ($past(ce) && !ce));
endmodule

// File: rtl/rxc_banks.sv
module rxc_banks #(
    parameter int DISP_W = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmt_lo,
    input  logic cmt_hi,
    input  logic [DISP_W+rxc_pkg::CTRL_W:0] pay,
    output logic [DISP_W-1:0] disp_lo,
    output logic [DISP_W-1:0] disp_hi,
    output rxc_pkg::ctrl_t    ctrl,
    output logic upd_lo,
    output logic upd_hi
);
    import rxc_pkg::*;
    localparam int CFG_LSB = DISP_W + PAD_BITS;

    typedef struct packed {
        logic [DISP_W-1:0] lo;
        logic [DISP_W-1:0] hi;
        ctrl_t             cf;
        logic              s_lo;
        logic              s_hi;
    } bk_t;

    bk_t b_d, b_q;

    always_comb begin
        b_d      = b_q;
        b_d.s_lo = cmt_lo;
        b_d.s_hi = cmt_hi;
        if (cmt_lo) begin
            b_d.lo = pay[DISP_W-1:0];
            b_d.cf = ctrl_t'(pay[CFG_LSB +: CFG_BITS]);
        end
        if (cmt_hi) begin
            b_d.hi = pay[DISP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign disp_lo = b_q.lo;
    assign disp_hi = b_q.hi;
    assign ctrl    = b_q.cf;
    assign upd_lo  = b_q.s_lo;
    assign upd_hi  = b_q.s_hi;

    // R7
    lo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_lo |=> !upd_lo);
    // R7
    hi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hi |=> !upd_hi);
    // R7
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_lo |-> ($stable(disp_lo) && $stable(ctrl)));
    // R8
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_hi |-> $stable(disp_hi));
endmodule

// File: rtl/addr_frame_rx.sv
module addr_frame_rx #(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] DEV_ADDR = 8'h44,
    parameter int         DISP_W   = 44,
    parameter int         SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [DISP_W-1:0] disp_lo,
    output logic [DISP_W-1:0] disp_hi,
    output logic [2:0]        port_sel,
    output logic              bias_half,
    output logic              seg_blank,
    output logic              save_mode,
    output logic              upd_lo,
    output logic              upd_hi
);
    import rxc_pkg::*;
    localparam int PAY_W = DISP_W + CTRL_W + 1;

    logic [2:0]       sy;
    logic             cmt_lo, cmt_hi;
    logic [PAY_W-1:0] pay;
    ctrl_t            ctrl;

    rxc_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ser_en, ser_clk, ser_dat}), .q(sy)
    );

    rxc_frame #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR), .DISP_W(DISP_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .ce(sy[2]), .sck(sy[1]), .dat(sy[0]),
        .cmt_lo(cmt_lo), .cmt_hi(cmt_hi), .pay(pay)
    );

    rxc_banks #(.DISP_W(DISP_W)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .cmt_lo(cmt_lo), .cmt_hi(cmt_hi), .pay(pay),
        .disp_lo(disp_lo), .disp_hi(disp_hi), .ctrl(ctrl),
        .upd_lo(upd_lo), .upd_hi(upd_hi)
    );

    assign port_sel  = ctrl.port_sel;
    assign bias_half = ctrl.bias_half;
    assign seg_blank = ctrl.seg_blank;
    assign save_mode = ctrl.save_mode;

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_lo && upd_hi));
endmodule

// File: tb/sim_addr_frame_rx.sv
module sim_addr_frame_rx;
    localparam int HP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic [43:0] disp_lo, disp_hi;
    logic [2:0]  port_sel;
    logic bias_half, seg_blank, save_mode, upd_lo, upd_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // expected item: {hi_bank, ctrl6, disp44}
    logic [50:0] exp_q[$];
    logic [43:0] m_lo = '0, m_hi = '0;
    logic [5:0]  m_cf = '0;

    always #4 clk = ~clk;

    addr_frame_rx u0 (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .disp_lo(disp_lo), .disp_hi(disp_hi), .port_sel(port_sel),
        .bias_half(bias_half), .seg_blank(seg_blank), .save_mode(save_mode),
        .upd_lo(upd_lo), .upd_hi(upd_hi)
    );

    function automatic logic [5:0] cf_now();
        return {save_mode, seg_blank, bias_half, port_sel};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare on every strobe
    always @(negedge clk) begin
        if (rst_n && !done && (upd_lo || upd_hi)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7", "unexpected strobe", {62'd0, upd_hi, upd_lo}, 64'd0);
            end else begin
                logic [50:0] it;
                it = exp_q.pop_front();
                chk(upd_hi == it[50] && upd_lo == !it[50], "R5", "strobe bank",
                    {62'd0, upd_hi, upd_lo}, {62'd0, it[50], !it[50]});
                if (it[50])
                    chk(disp_hi == it[43:0], "R5", "hi bank at strobe", 64'(disp_hi), 64'(it[43:0]));
                else begin
                    chk(disp_lo == it[43:0], "R3", "lo bank at strobe", 64'(disp_lo), 64'(it[43:0]));
                    chk(cf_now() == it[49:44], "R4", "ctrl at strobe", 64'(cf_now()), 64'(it[49:44]));
                end
            end
        end
    end

    function automatic logic [55:0] mk_lo(input logic [43:0] d, input logic [5:0] cf,
                                           input logic [4:0] pad);
        logic [55:0] p;
        p[43:0]  = d;
        p[48:44] = pad;
        p[49]    = cf[0];
        p[50]    = cf[1];
        p[51]    = cf[2];
        p[52]    = cf[3];
        p[53]    = cf[4];
        p[54]    = cf[5];
        p[55]    = 1'b0;
        return p;
    endfunction

    function automatic logic [55:0] mk_hi(input logic [43:0] d, input logic [10:0] fix);
        return {1'b1, fix, d};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_addr(input logic [7:0] a);
        for (int i = 0; i < 8; i++) begin
            ser_dat = a[i];
            tick(HP); ser_clk = 1'b1;
            tick(HP); ser_clk = 1'b0;
        end
    endtask

    task automatic check_all(input string tag);
        chk(exp_q.size() == 0, "R7", {tag, " missing strobe"}, 64'(exp_q.size()), 64'd0);
        chk(disp_lo == m_lo, "R3", {tag, " disp_lo"}, 64'(disp_lo), 64'(m_lo));
        chk(disp_hi == m_hi, "R8", {tag, " disp_hi"}, 64'(disp_hi), 64'(m_hi));
        chk(cf_now() == m_cf, "R4", {tag, " ctrl"}, 64'(cf_now()), 64'(m_cf));
    endtask

    // driver: compute expectation, push, then send the frame
    task automatic frame(input string tag, input logic [7:0] a, input logic [55:0] p, input int n);
        bit ok;
        ok = (a == 8'h44) && (n == 56) && (!p[55] || p[54:44] == '0);
        if (ok) begin
            if (p[55]) begin
                m_hi = p[43:0];
                exp_q.push_back({1'b1, 6'd0, p[43:0]});
            end else begin
                m_lo = p[43:0];
                m_cf = {p[54], p[53], p[52], p[51], p[50], p[49]};
                exp_q.push_back({1'b0, m_cf, p[43:0]});
            end
        end
        ser_en = 1'b0;
        send_addr(a);
        tick(HP); ser_en = 1'b1; tick(HP);
        for (int i = 0; i < n; i++) begin
            ser_dat = (i < 56) ? p[i] : 1'b0;
            tick(HP); ser_clk = 1'b1;
            tick(HP); ser_clk = 1'b0;
        end
        tick(HP); ser_en = 1'b0;
        tick(16);
        check_all(tag);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        chk(disp_lo == '0 && disp_hi == '0, "R1", "reset banks", 64'(disp_lo | disp_hi), 64'd0);
        chk(cf_now() == '0 && !upd_lo && !upd_hi, "R1", "reset ctrl/strobes",
            {56'd0, cf_now(), upd_hi, upd_lo}, 64'd0);

        // R3 R4: low frame
        frame("R3 lo basic", 8'h44, mk_lo(44'hA5C_3F01_9E27, 6'b101_011, 5'd0), 56);
        // R5: high frame
        frame("R5 hi basic", 8'h44, mk_hi(44'h123_4567_89AB, 11'd0), 56);
        // R4: padding bits ignored
        frame("R4 pad ignored", 8'h44, mk_lo(44'h0F0_F0F0_F0F0, 6'b010_100, 5'b11111), 56);
        // R2: wrong address
        frame("R2 bad addr", 8'h45, mk_lo(44'hFFF_FFFF_FFFF, 6'b111_111, 5'd0), 56);
        frame("R2 bad addr2", 8'h22, mk_hi(44'h0, 11'd0), 56);
        // R6: count boundaries
        frame("R6 short", 8'h44, mk_lo(44'h777_7777_7777, 6'b000_111, 5'd0), 55);
        frame("R6 long", 8'h44, mk_hi(44'h888_8888_8888, 11'd0), 57);
        // R5: nonzero fixed bits in high frame
        frame("R5 fixed nz", 8'h44, mk_hi(44'hBAD_BAD_BAD0, 11'b100_0000_0000), 56);
        frame("R5 fixed nz lsb", 8'h44, mk_hi(44'hBAD_BAD_BAD1, 11'b000_0000_0001), 56);
        // R3 R4: all ones and all zeros
        frame("R3 ones", 8'h44, mk_lo('1, 6'b111_111, 5'd0), 56);
        frame("R3 zeros", 8'h44, mk_lo('0, 6'b000_000, 5'd0), 56);
        // R7: address clocking with enable held low only
        ser_en = 1'b0;
        send_addr(8'h44);
        send_addr(8'h44);
        tick(16);
        check_all("R7 no enable phase");
        // R9: back-to-back, both orders
        frame("R9 pair lo", 8'h44, mk_lo(44'h5A5_A5A5_A5A5, 6'b110_001, 5'd0), 56);
        frame("R9 pair hi", 8'h44, mk_hi(44'hC3C_3C3C_3C3C, 11'd0), 56);
        frame("R9 pair hi2", 8'h44, mk_hi(44'h001_0000_0001, 11'd0), 56);
        frame("R9 pair lo2", 8'h44, mk_lo(44'h800_0000_0001, 6'b001_010, 5'd0), 56);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule